// File: doc/BRIEF.md
# Operand-Queue Execute Engine

This block is the compute half of a processing element that has been split into an access side and an execute side. The op stream carries only the operation kind, never an operand location. Every source and destination address comes from one of three address queues, which a separate address engine fills. Because of this split, one short op sequence can be applied to many data items. The access side alone decides where the data lives.

Each cycle the engine looks at the head of its op queue. It issues the op only when every address queue that op needs holds an entry. On issue it pops those entries and starts synchronous reads:
- the input buffer supplies source 0;
- the weight buffer supplies source 1;
- the output buffer supplies the destination, for accumulate and pool.

One cycle later the result is written to the output buffer at the popped destination address. A repeat op makes the next op run several times without that op being fetched again.

Top module: `opq_exec_engine`

## Requirements
- R1: At most one op leaves the op queue per cycle, and `op_pop` is never high while `op_empty` is high.
- R2: While the op queue is empty, no address queue is popped and no buffer read is started. The only write that can still occur is the one for an op issued in the previous cycle.
- R3: An op issues only when every address queue it needs is non-empty. If any of them is empty, nothing is popped and nothing is read until the missing entry arrives. On issue, each needed queue is popped exactly once.
- R4: Opcodes are 3 bits. 0 = ADD (src0, src1, dst), 1 = MUL (src0, src1, dst), 2 = MAC (src0, src1, dst), 3 = MAX (src0, dst), 4 = RELU (src0, dst), 5 = REPEAT (no addresses).
- R5: ADD writes the sign-extended sum of the two 16-bit signed sources. MUL writes their full signed product. Both results are 32 bits.
- R6: MAC reads the destination, adds the signed product and writes the sum back. Back-to-back MACs to the same address accumulate correctly, although the buffer returns the old value on a read in the same cycle as a write to that address.
- R7: MAX writes the larger of sign-extended source 0 and the current destination value.
- R8: RELU writes sign-extended source 0 when it is non-negative, and 0 otherwise.
- R9: REPEAT pops no address and makes the next op execute N times, where N is the repeat register, loaded through `rpt_load`/`rpt_value` and reset to 1. That op leaves the op queue only after its last run. N = 0 behaves as 1.
- R10: The write for an issued op occurs exactly one cycle after issue, at the destination address popped at issue.
- R11: Opcodes 6 and 7 are popped and discarded with no address pop, no read and no write.
- R12: After reset, no queue is popped and no buffer read or write is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rpt_load | input | 1 | Load repeat register |
| rpt_value | input | 8 | Repeat count to load |
| op_empty | input | 1 | Op queue empty |
| op_code | input | 3 | Op at queue head |
| op_pop | output | 1 | Pop op queue |
| src0_empty | input | 1 | Source-0 address queue empty |
| src0_addr | input | 8 | Source-0 address at head |
| src0_pop | output | 1 | Pop source-0 queue |
| src1_empty | input | 1 | Source-1 address queue empty |
| src1_addr | input | 8 | Source-1 address at head |
| src1_pop | output | 1 | Pop source-1 queue |
| dst_empty | input | 1 | Destination address queue empty |
| dst_addr | input | 8 | Destination address at head |
| dst_pop | output | 1 | Pop destination queue |
| in_rd_en | output | 1 | Input buffer read enable |
| in_rd_addr | output | 8 | Input buffer read address |
| in_rd_data | input | 16 | Input buffer data, one cycle after enable |
| wt_rd_en | output | 1 | Weight buffer read enable |
| wt_rd_addr | output | 8 | Weight buffer read address |
| wt_rd_data | input | 16 | Weight buffer data, one cycle after enable |
| out_rd_en | output | 1 | Output buffer read enable |
| out_rd_addr | output | 8 | Output buffer read address |
| out_rd_data | input | 32 | Output buffer data, one cycle after enable |
| out_wr_en | output | 1 | Output buffer write enable |
| out_wr_addr | output | 8 | Output buffer write address |
| out_wr_data | output | 32 | Output buffer write data |

## Verification
The assertions rely on three properties of the inputs:
- each queue's `*_empty` flag is accurate;
- the head entry holds steady until it is popped;
- every buffer answers a read exactly one cycle later, with the value it held before any write in that cycle.

The bench enforces these with its own queue and buffer models. Queue indices advance only on the engine's pop strobes, and buffer reads and writes are nonblocking at the same clock edge. Stimulus is loaded while the op queue is held empty and then released, so every op sequence runs back to back from one known starting point.

// File: rtl/opq_exec_engine.sv
module opq_exec_engine #(
  parameter int DW   = 16,
  parameter int ACCW = 32,
  parameter int AW   = 8,
  parameter int RPTW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rpt_load,
  input  logic [RPTW-1:0] rpt_value,
  input  logic            op_empty,
  input  logic [2:0]      op_code,
  output logic            op_pop,
  input  logic            src0_empty,
  input  logic [AW-1:0]   src0_addr,
  output logic            src0_pop,
  input  logic            src1_empty,
  input  logic [AW-1:0]   src1_addr,
  output logic            src1_pop,
  input  logic            dst_empty,
  input  logic [AW-1:0]   dst_addr,
  output logic            dst_pop,
  output logic            in_rd_en,
  output logic [AW-1:0]   in_rd_addr,
  input  logic [DW-1:0]   in_rd_data,
  output logic            wt_rd_en,
  output logic [AW-1:0]   wt_rd_addr,
  input  logic [DW-1:0]   wt_rd_data,
  output logic            out_rd_en,
  output logic [AW-1:0]   out_rd_addr,
  input  logic [ACCW-1:0] out_rd_data,
  output logic            out_wr_en,
  output logic [AW-1:0]   out_wr_addr,
  output logic [ACCW-1:0] out_wr_data
);
  localparam logic [2:0] K_ADD = 3'd0, K_MUL = 3'd1, K_MAC = 3'd2,
                         K_MAX = 3'd3, K_RELU = 3'd4, K_REP = 3'd5;

  logic            alu_op, need_s1, need_dst_rd, is_rep, ready, issue, last_run;
  logic [RPTW-1:0] rpt_reg, rpt_left;
  logic            rpt_armed;
  logic            s1_v, s1_fwd;
  logic [2:0]      s1_op;
  logic [AW-1:0]   s1_dst;
  logic [ACCW-1:0] s1_fwd_data, result;

  assign alu_op      = op_code <= K_RELU;
  assign need_s1     = op_code <= K_MAC;
  assign need_dst_rd = (op_code == K_MAC) || (op_code == K_MAX);
  assign is_rep      = op_code == K_REP;

  assign ready = !op_empty && (!alu_op || (!src0_empty && !dst_empty && (!need_s1 || !src1_empty)));
  assign issue = ready && alu_op;
  assign last_run = !rpt_armed || (rpt_left <= 1);

  assign op_pop   = ready && (!alu_op || last_run);
  assign src0_pop = issue;
  assign dst_pop  = issue;
  assign src1_pop = issue && need_s1;

  assign in_rd_en    = issue;
  assign in_rd_addr  = src0_addr;
  assign wt_rd_en    = issue && need_s1;
  assign wt_rd_addr  = src1_addr;
  assign out_rd_en   = issue && need_dst_rd;
  assign out_rd_addr = dst_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rpt_reg   <= RPTW'(1);
      rpt_armed <= 1'b0;
      rpt_left  <= '0;
    end else begin
      if (rpt_load) rpt_reg <= rpt_value;
      if (ready && is_rep) begin
        rpt_armed <= 1'b1;
        rpt_left  <= (rpt_reg == 0) ? RPTW'(1) : rpt_reg;
      end else if (issue && rpt_armed) begin
        if (rpt_left <= 1) rpt_armed <= 1'b0;
        else rpt_left <= rpt_left - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v        <= 1'b0;
      s1_op       <= '0;
      s1_dst      <= '0;
      s1_fwd      <= 1'b0;
      s1_fwd_data <= '0;
    end else begin
      s1_v        <= issue;
      s1_op       <= op_code;
      s1_dst      <= dst_addr;
      s1_fwd      <= out_rd_en && s1_v && (s1_dst == dst_addr);
      s1_fwd_data <= result;
    end
  end

  logic signed [DW-1:0]     opa, opb;
  logic signed [2*DW-1:0]   prod;
  logic signed [ACCW-1:0]   a_x, b_x, p_x, d_x;

  assign opa  = in_rd_data;
  assign opb  = wt_rd_data;
  assign prod = opa * opb;
  assign a_x  = opa;
  assign b_x  = opb;
  assign p_x  = prod;
  assign d_x  = s1_fwd ? s1_fwd_data : out_rd_data;

  always_comb begin
    case (s1_op)
      K_ADD:   result = a_x + b_x;
      K_MUL:   result = p_x;
      K_MAC:   result = d_x + p_x;
      K_MAX:   result = (a_x > d_x) ? a_x : d_x;
      default: result = opa[DW-1] ? '0 : a_x;
    endcase
  end

  assign out_wr_en   = s1_v;
  assign out_wr_addr = s1_dst;
  assign out_wr_data = result;

  AST_OP_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n) op_pop |-> !op_empty); // R1
  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    op_empty |-> !(src0_pop || src1_pop || dst_pop || in_rd_en || wt_rd_en || out_rd_en)); // R2
  AST_NO_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    !((src0_pop && src0_empty) || (src1_pop && src1_empty) || (dst_pop && dst_empty))); // R3
  AST_WHOLE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (src1_pop || dst_pop) |-> (src0_pop && dst_pop)); // R3
  AST_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rst_n) dst_pop |=> out_wr_en); // R10
  AST_WRITE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dst_pop) |-> (out_wr_addr == $past(dst_addr))); // R10
  AST_WRITE_ONLY_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_pop |=> !out_wr_en); // R2
endmodule

// File: tb/opq_exec_engine_tb.sv
module opq_exec_engine_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, hold, rpt_load;
  logic [7:0] rpt_value;
  logic [2:0] op_q [0:255];
  logic [7:0] s0_q [0:255], s1_q [0:255], d_q [0:255];
  logic [7:0] op_h = 0, op_t = 0, s0_h = 0, s0_t = 0, s1_h = 0, s1_t = 0, d_h = 0, d_t = 0;
  logic [15:0] in_mem [0:255], wt_mem [0:255];
  logic [31:0] out_mem [0:255];
  logic [15:0] in_q, wt_q;
  logic [31:0] out_q;

  logic op_pop, src0_pop, src1_pop, dst_pop, in_rd_en, wt_rd_en, out_rd_en, out_wr_en;
  logic [7:0] in_rd_addr, wt_rd_addr, out_rd_addr, out_wr_addr;
  logic [31:0] out_wr_data;

  opq_exec_engine dut_i (
    .clk(clk), .rst_n(rst_n), .rpt_load(rpt_load), .rpt_value(rpt_value),
    .op_empty(hold || op_h == op_t), .op_code(op_q[op_h]), .op_pop(op_pop),
    .src0_empty(s0_h == s0_t), .src0_addr(s0_q[s0_h]), .src0_pop(src0_pop),
    .src1_empty(s1_h == s1_t), .src1_addr(s1_q[s1_h]), .src1_pop(src1_pop),
    .dst_empty(d_h == d_t), .dst_addr(d_q[d_h]), .dst_pop(dst_pop),
    .in_rd_en(in_rd_en), .in_rd_addr(in_rd_addr), .in_rd_data(in_q),
    .wt_rd_en(wt_rd_en), .wt_rd_addr(wt_rd_addr), .wt_rd_data(wt_q),
    .out_rd_en(out_rd_en), .out_rd_addr(out_rd_addr), .out_rd_data(out_q),
    .out_wr_en(out_wr_en), .out_wr_addr(out_wr_addr), .out_wr_data(out_wr_data));

  always @(posedge clk) begin
    if (op_pop) op_h <= op_h + 1;
    if (src0_pop) s0_h <= s0_h + 1;
    if (src1_pop) s1_h <= s1_h + 1;
    if (dst_pop) d_h <= d_h + 1;
    if (in_rd_en) in_q <= in_mem[in_rd_addr];
    if (wt_rd_en) wt_q <= wt_mem[wt_rd_addr];
    if (out_rd_en) out_q <= out_mem[out_rd_addr];
    if (out_wr_en) out_mem[out_wr_addr] <= out_wr_data;
  end

  int checks = 0, fails = 0, cyc = 0;

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%h) expected %0d (0x%h)", req, act, act, exp, exp);
    end
  endtask

  task automatic push_op(logic [2:0] c); op_q[op_t] = c; op_t = op_t + 1; endtask
  task automatic push_s0(logic [7:0] a); s0_q[s0_t] = a; s0_t = s0_t + 1; endtask
  task automatic push_s1(logic [7:0] a); s1_q[s1_t] = a; s1_t = s1_t + 1; endtask
  task automatic push_d(logic [7:0] a); d_q[d_t] = a; d_t = d_t + 1; endtask

  task automatic drain();
    for (int i = 0; i < 40; i++) begin
      if (op_h == op_t) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    hold = 1'b1;
  endtask

  // {op, src0 value, src1 value, initial dst, expected dst}
  localparam logic [98:0] VEC [0:10] = '{
    {3'd0, 16'd100,    -16'sd30,  32'd0,      32'd70},
    {3'd0, 16'h8000,   16'h8000,  32'd0,      -32'sd65536},
    {3'd0, 16'd32767,  16'd1,     32'd0,      32'd32768},
    {3'd1, 16'd300,    -16'sd200, 32'd0,      -32'sd60000},
    {3'd1, 16'h8000,   16'h8000,  32'd0,      32'd1073741824},
    {3'd2, 16'd7,      16'd8,     32'd1000,   32'd1056},
    {3'd2, -16'sd3,    16'd5,     32'd10,     -32'sd5},
    {3'd3, 16'd50,     16'd0,     32'd20,     32'd50},
    {3'd3, -16'sd5,    16'd0,     -32'sd1,    -32'sd1},
    {3'd4, -16'sd7,    16'd0,     32'd99,     32'd0},
    {3'd4, 16'd1234,   16'd0,     32'd99,     32'd1234}
  };

  initial begin
    logic [7:0] oh0, dh0;
    hold = 1'b1; rst_n = 1'b0; rpt_load = 1'b0; rpt_value = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 pops", {28'd0, op_pop, src0_pop, src1_pop, dst_pop}, 32'd0);
    check("R12 buffer access", {28'd0, in_rd_en, wt_rd_en, out_rd_en, out_wr_en}, 32'd0);

    // table: R4 R5 R6 R7 R8
    for (int v = 0; v < 11; v++) begin
      logic [2:0] c;
      c = VEC[v][98:96];
      in_mem[10] = VEC[v][95:80];
      wt_mem[20] = VEC[v][79:64];
      out_mem[30] = VEC[v][63:32];
      push_op(c); push_s0(8'd10); push_d(8'd30);
      if (c <= 3'd2) push_s1(8'd20);
      hold = 1'b0;
      drain();
      check($sformatf("R4/R5-R8 vector %0d op %0d", v, c), out_mem[30], VEC[v][31:0]);
    end

    // R6 back-to-back MAC to one address
    out_mem[40] = 32'd0; in_mem[41] = 16'd2; wt_mem[42] = 16'd3;
    for (int i = 0; i < 3; i++) begin push_op(3'd2); push_s0(8'd41); push_s1(8'd42); push_d(8'd40); end
    hold = 1'b0; drain();
    check("R6 back-to-back MAC", out_mem[40], 32'd18);

    // R2 empty op queue with addresses waiting
    in_mem[90] = -16'sd1; out_mem[91] = 32'd55;
    push_s0(8'd90); push_d(8'd91);
    hold = 1'b0;
    for (int i = 0; i < 4; i++) begin
      #1;
      check("R2 no access while op queue empty",
            {26'd0, src0_pop, dst_pop, in_rd_en, out_rd_en, out_wr_en, op_pop}, 32'd0);
      @(negedge clk);
    end
    check("R2 dst untouched", out_mem[91], 32'd55);
    push_op(3'd4); drain();
    check("R2/R8 leftover addresses used", out_mem[91], 32'd0);

    // R3 stall whole until src1 arrives
    in_mem[100] = 16'd4; out_mem[101] = 32'd5; wt_mem[102] = 16'd6;
    push_op(3'd2); push_s0(8'd100); push_d(8'd101);
    hold = 1'b0;
    for (int i = 0; i < 4; i++) begin
      #1;
      check("R3 no partial pop", {28'd0, op_pop, src0_pop, dst_pop, in_rd_en}, 32'd0);
      @(negedge clk);
    end
    push_s1(8'd102); drain();
    check("R3 MAC after stall", out_mem[101], 32'd29);

    // R10 write timing and R1 single pop
    in_mem[110] = 16'd9; wt_mem[111] = 16'd1; out_mem[112] = 32'd0;
    push_op(3'd0); push_s0(8'd110); push_s1(8'd111); push_d(8'd112);
    hold = 1'b0; #1;
    check("R1 op pop at issue", {30'd0, op_pop, dst_pop}, 32'd3);
    @(negedge clk);
    check("R10 write one cycle later", {23'd0, out_wr_en, out_wr_addr}, {23'd0, 1'b1, 8'd112});
    check("R10 write data", out_wr_data, 32'd10);
    drain();

    // R11 undefined opcode
    in_mem[120] = 16'd77; out_mem[121] = 32'd1;
    push_op(3'd6); push_op(3'd4); push_s0(8'd120); push_d(8'd121);
    hold = 1'b0; #1;
    check("R11 discard pops op only", {29'd0, op_pop, src0_pop, dst_pop}, 32'd4);
    drain();
    check("R11 following op intact", out_mem[121], 32'd77);

    // R9 repeat of four
    @(negedge clk); rpt_value = 8'd4; rpt_load = 1'b1; @(negedge clk); rpt_load = 1'b0;
    for (int i = 0; i < 4; i++) begin
      in_mem[50+i] = 16'(i + 1); wt_mem[60+i] = 16'd2;
      push_s0(8'(50+i)); push_s1(8'(60+i)); push_d(8'd70);
    end
    out_mem[70] = 32'd0; in_mem[54] = 16'd5; wt_mem[64] = 16'd6; out_mem[71] = 32'd0;
    push_s0(8'd54); push_s1(8'd64); push_d(8'd71);
    oh0 = op_h; dh0 = d_h;
    push_op(3'd5); push_op(3'd2); push_op(3'd0);
    hold = 1'b0; drain();
    check("R9 repeated MAC", out_mem[70], 32'd20);
    check("R9 next op once", out_mem[71], 32'd11);
    check("R9 ops consumed", 32'(8'(op_h - oh0)), 32'd3);
    check("R9 dst pops", 32'(8'(d_h - dh0)), 32'd5);

    // R9 zero count acts as one
    @(negedge clk); rpt_value = 8'd0; rpt_load = 1'b1; @(negedge clk); rpt_load = 1'b0;
    in_mem[80] = 16'd9; out_mem[81] = 32'd0;
    oh0 = op_h; dh0 = d_h;
    push_op(3'd5); push_op(3'd4); push_s0(8'd80); push_d(8'd81);
    hold = 1'b0; drain();
    check("R9 zero count result", out_mem[81], 32'd9);
    check("R9 zero count ops consumed", 32'(8'(op_h - oh0)), 32'd2);
    check("R9 zero count dst pops", 32'(8'(d_h - dh0)), 32'd1);

    finish_run();
  end
endmodule